// File: doc/BRIEF.md
# NOR Flash Block-Erase Command Controller

This block is the command front end and erase sequencer of a byte-wide NOR flash model. It watches bus write cycles, each a one-clock write strobe with an address and a data byte, and recognises the six-write block-erase command. The first two writes and the fourth and fifth writes are unlock writes. The third write is the erase-setup code. The sixth write is the confirm code, and the block bits of its address name the first block to erase. After the confirm the controller keeps an acceptance window open. Further confirm writes, with no unlock writes before them, add more blocks to the same erase. Each of these writes restarts the window. If any other value is written while the window is open, the command is dropped and the controller returns to read-array mode.

When the window expires, the queued blocks are erased one after another, lowest index first, and each block takes a fixed number of clocks. Once the sixth write has been taken, reads return a status byte instead of array data until the operation leaves the busy states. The status byte carries four bits. A polling bit stays low while the operation is unfinished. A toggle bit flips on every status read. A failure bit flags an erase that ran past its cycle budget. A timer bit tells the window phase from the erase phase. While the erase runs, only suspend and reset writes have an effect. A test input stalls erase progress so that the failure path can be reached. The array itself is a stub that reads as erased bytes.

Top module: `nor_erase_engine`

## Requirements
- R1: After reset the controller is in read-array mode, and rdData and every read return 8'hFF. This is the array stub value, so bit 7 reads 1 whenever the array is shown.
- R2: The writes 8'hAA at low address 15'h5555, 8'h55 at 15'h2AAA, 8'h80 at 15'h5555, 8'hAA at 15'h5555, 8'h55 at 15'h2AAA, then 8'h30 at any address open the acceptance window. The next read returns the status byte. It has bit 7 = 0, bit 5 = 0, bit 3 = 0 and bits 4, 2, 1 and 0 all 0.
- R3: If the address or the data of any of the first five writes differs from its expected value, the sequence ends and the controller returns to read-array mode. A confirm that follows then has no effect.
- R4: A further 8'h30 write inside the window adds the block at address bits [17:15] to the queue and restarts the window. Erase begins WIN_CYC clocks after the last confirm edge. A block queued twice is erased once.
- R5: Any value other than 8'h30 written inside the window drops the command. The controller returns to read-array mode and no erase follows.
- R6: Status bit 3 reads 0 while the window runs and 1 once erasing has started, and it stays 1 in the failure state.
- R7: Status bit 6 reads 0 on the first status read after the sixth write and flips on each status read after that. Once the erase completes, reads show the array again and bit 6 no longer changes.
- R8: An erase of N distinct blocks takes N*BLK_CYC clocks. The controller then returns to read-array mode, where bit 7 reads 1.
- R9: While erasing, writes other than 8'hB0 and 8'hF0 are ignored, and they change neither the status nor the completion time.
- R10: 8'hB0 written during the erase suspends it. Reads then return array data and erase progress is frozen. 8'h30 written while suspended resumes the erase where it stopped.
- R11: 8'hF0 written during the erase, while suspended, or in the failure state abandons the operation and returns the controller to read-array mode.
- R12: If the erase has not completed after MAX_CYC erase clocks (forceFail stalls progress), the controller enters the failure state. There the status reads bit 5 = 1, bit 3 = 1 and bit 7 = 0, and bit 6 keeps toggling. All writes except 8'hF0 are ignored in this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 15+BLK_W | Bus address; bits [14:0] are decoded for unlock writes and the top BLK_W bits select the block |
| busWrData | input | 8 | Write data byte |
| busWr | input | 1 | Write strobe, one write per clock it is high |
| busRd | input | 1 | Read strobe; rdData is updated on the following edge |
| forceFail | input | 1 | Test input that stalls erase progress while high |
| rdData | output | 8 | Read data: the status byte in busy states, otherwise the array stub 8'hFF |

## Verification
The erase command is driven with a single block, with several blocks that include a repeated block and spaced confirms, with sequences corrupted in address or in data, and with a stray value inside the window. Together these separate the restart of the window from a fixed window, deduplicated queueing from a plain count of confirms, and a dropped command from one that went ahead. The erase phase is then disturbed with ignored writes, with a suspend and resume, with a reset and with a stalled erase. Each of these outcomes is distinct in the status bits and in the completion time. A clock-by-clock reference model predicts every read, so any shift of even one clock in the window or erase length shows up.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  localparam int UNLK_AW = 15;

  localparam logic [UNLK_AW-1:0] ADR_KEY_A = 15'h5555;
  localparam logic [UNLK_AW-1:0] ADR_KEY_B = 15'h2AAA;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

  localparam logic [7:0] ARRAY_STUB  = 8'hFF;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_KEY1,
    ST_KEY2,
    ST_ARMED,
    ST_KEY3,
    ST_KEY4,
    ST_WINDOW,
    ST_ERASE,
    ST_SUSP,
    ST_FAIL
  } ctrl_state_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrMap;
    logic addBlk;
    logic runWin;
    logic runErase;
    logic showStatus;
    logic failFlag;
    logic eraseFlag;
  } dp_ctrl_t;

endpackage

// File: rtl/nor_erase_dp.sv
module nor_erase_dp
  import nor_erase_pkg::*;
#(
  parameter int BLK_W   = 3,
  parameter int WIN_CYC = 48,
  parameter int BLK_CYC = 20,
  parameter int MAX_CYC = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         ctl,
  input  logic [BLK_W-1:0] blkSel,
  input  logic             busRd,
  input  logic             forceFail,
  output logic             winAtEnd,
  output logic             eraseAtEnd,
  output logic             budgetAtEnd,
  output logic [7:0]       rdData
);

  localparam int NBLK  = 1 << BLK_W;
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam int BLK_CW = $clog2(BLK_CYC + 1);
  localparam int MAX_W = $clog2(MAX_CYC + 1);

  logic [NBLK-1:0]   blkMap;
  logic [NBLK-1:0]   blkHit;
  logic [NBLK-1:0]   lowMask;
  logic              lastBlk;
  logic [WIN_W-1:0]  winCnt;
  logic [BLK_CW-1:0] blkCnt;
  logic [MAX_W-1:0]  totalCnt;
  logic              blkEnd;
  logic              toggleBit;
  logic [7:0]        statusByte;

  // one-hot decode of the addressed block
  for (genvar g = 0; g < NBLK; g++) begin : g_blk_dec
    assign blkHit[g] = (blkSel == BLK_W'(g));
  end

  assign lowMask = blkMap & (~blkMap + 1'b1);
  assign lastBlk = ((blkMap & (blkMap - 1'b1)) == '0);
  assign blkEnd  = (blkCnt == BLK_CW'(BLK_CYC - 1)) && !forceFail;

  assign winAtEnd    = (winCnt == WIN_W'(WIN_CYC - 1));
  assign eraseAtEnd  = blkEnd && lastBlk;
  assign budgetAtEnd = (totalCnt == MAX_W'(MAX_CYC - 1));

  // queued block bitmap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkMap <= '0;
    end else if (ctl.clrMap) begin
      blkMap <= ctl.addBlk ? blkHit : '0;
    end else if (ctl.addBlk) begin
      blkMap <= blkMap | blkHit;
    end else if (ctl.runErase && blkEnd) begin
      blkMap <= blkMap & ~lowMask;
    end
  end

  // acceptance window timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (ctl.clrMap || ctl.addBlk) begin
      winCnt <= '0;
    end else if (ctl.runWin) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  // per-block and total erase counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkCnt   <= '0;
      totalCnt <= '0;
    end else if (ctl.clrMap || ctl.addBlk) begin
      blkCnt   <= '0;
      totalCnt <= '0;
    end else if (ctl.runErase) begin
      totalCnt <= totalCnt + 1'b1;
      if (!forceFail) begin
        blkCnt <= blkEnd ? '0 : blkCnt + 1'b1;
      end
    end
  end

  // status byte: polling low while busy, toggle, failure, timer phase
  assign statusByte = {1'b0, toggleBit, ctl.failFlag, 1'b0,
                       ctl.eraseFlag, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleBit <= 1'b0;
      rdData    <= ARRAY_STUB;
    end else begin
      if (ctl.clrMap) begin
        toggleBit <= 1'b0;
      end else if (busRd && ctl.showStatus) begin
        toggleBit <= ~toggleBit;
      end
      if (busRd) begin
        rdData <= ctl.showStatus ? statusByte : ARRAY_STUB;
      end
    end
  end

  // R4: a confirm leaves its block queued
  a_r4_block_queued: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addBlk |=> ((blkMap & $past(blkHit)) != '0));

  // R8: erase never runs with an empty queue
  a_r8_queue_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.runErase |-> (blkMap != '0));

  // R7: each status read flips the toggle bit
  a_r7_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && ctl.showStatus && !ctl.clrMap) |=> (toggleBit != $past(toggleBit)));

  // R10: erase progress frozen when not running
  a_r10_progress_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runErase && !ctl.clrMap && !ctl.addBlk) |=> $stable(totalCnt));

endmodule

// File: rtl/nor_erase_fsm.sv
module nor_erase_fsm
  import nor_erase_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [UNLK_AW-1:0] keyAddr,
  input  logic [7:0]         busWrData,
  input  logic               busWr,
  input  logic               winAtEnd,
  input  logic               eraseAtEnd,
  input  logic               budgetAtEnd,
  output dp_ctrl_t           ctl
);

  ctrl_state_e state, stNext;

  logic isKeyA, isKeyB, isSetup, isConfirm, isSuspend, isReset;

  assign isKeyA    = (keyAddr == ADR_KEY_A) && (busWrData == CMD_KEY_A);
  assign isKeyB    = (keyAddr == ADR_KEY_B) && (busWrData == CMD_KEY_B);
  assign isSetup   = (keyAddr == ADR_KEY_A) && (busWrData == CMD_SETUP);
  assign isConfirm = (busWrData == CMD_CONFIRM);
  assign isSuspend = (busWrData == CMD_SUSPEND);
  assign isReset   = (busWrData == CMD_RESET);

  always_comb begin
    stNext         = state;
    ctl            = '0;
    ctl.showStatus = (state == ST_WINDOW) || (state == ST_ERASE) || (state == ST_FAIL);
    ctl.eraseFlag  = (state == ST_ERASE) || (state == ST_FAIL);
    ctl.failFlag   = (state == ST_FAIL);
    case (state)
      ST_ARRAY: if (busWr && isKeyA) stNext = ST_KEY1;
      ST_KEY1:  if (busWr) stNext = isKeyB  ? ST_KEY2  : ST_ARRAY;
      ST_KEY2:  if (busWr) stNext = isSetup ? ST_ARMED : ST_ARRAY;
      ST_ARMED: if (busWr) stNext = isKeyA  ? ST_KEY3  : ST_ARRAY;
      ST_KEY3:  if (busWr) stNext = isKeyB  ? ST_KEY4  : ST_ARRAY;
      ST_KEY4: begin
        if (busWr) begin
          if (isConfirm) begin
            stNext     = ST_WINDOW;
            ctl.clrMap = 1'b1;
            ctl.addBlk = 1'b1;
          end else begin
            stNext = ST_ARRAY;
          end
        end
      end
      ST_WINDOW: begin
        if (busWr) begin
          if (isConfirm) begin
            ctl.addBlk = 1'b1;
          end else begin
            stNext     = ST_ARRAY;
            ctl.clrMap = 1'b1;
          end
        end else begin
          ctl.runWin = 1'b1;
          if (winAtEnd) stNext = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (busWr && isReset) begin
          stNext = ST_ARRAY;
        end else if (busWr && isSuspend) begin
          stNext = ST_SUSP;
        end else begin
          ctl.runErase = 1'b1;
          if (eraseAtEnd)       stNext = ST_ARRAY;
          else if (budgetAtEnd) stNext = ST_FAIL;
        end
      end
      ST_SUSP: begin
        if (busWr && isConfirm)    stNext = ST_ERASE;
        else if (busWr && isReset) stNext = ST_ARRAY;
      end
      ST_FAIL: if (busWr && isReset) stNext = ST_ARRAY;
      default: stNext = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ARRAY;
    else       state <= stNext;
  end

  // R5: a stray value inside the window drops the command
  a_r5_window_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && busWr && !isConfirm) |=> (state == ST_ARRAY));

  // R9: unrelated writes do not disturb a running erase
  a_r9_erase_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && busWr && !isSuspend && !isReset && !eraseAtEnd && !budgetAtEnd)
    |=> (state == ST_ERASE));

  // R11: reset write abandons any busy operation
  a_r11_reset_exits: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ERASE || state == ST_SUSP || state == ST_FAIL) && busWr && isReset)
    |=> (state == ST_ARRAY));

  // R12: failure state held until a reset write
  a_r12_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL && !(busWr && isReset)) |=> (state == ST_FAIL));

endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine
  import nor_erase_pkg::*;
#(
  parameter int BLK_W   = 3,
  parameter int WIN_CYC = 48,
  parameter int BLK_CYC = 20,
  parameter int MAX_CYC = 200
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [UNLK_AW+BLK_W-1:0] busAddr,
  input  logic [7:0]               busWrData,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic                     forceFail,
  output logic [7:0]               rdData
);

  localparam int ADDR_W = UNLK_AW + BLK_W;

  dp_ctrl_t ctl;
  logic     winAtEnd;
  logic     eraseAtEnd;
  logic     budgetAtEnd;

  nor_erase_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .keyAddr    (busAddr[UNLK_AW-1:0]),
    .busWrData  (busWrData),
    .busWr      (busWr),
    .winAtEnd   (winAtEnd),
    .eraseAtEnd (eraseAtEnd),
    .budgetAtEnd(budgetAtEnd),
    .ctl        (ctl)
  );

  nor_erase_dp #(
    .BLK_W  (BLK_W),
    .WIN_CYC(WIN_CYC),
    .BLK_CYC(BLK_CYC),
    .MAX_CYC(MAX_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .blkSel     (busAddr[ADDR_W-1:UNLK_AW]),
    .busRd      (busRd),
    .forceFail  (forceFail),
    .winAtEnd   (winAtEnd),
    .eraseAtEnd (eraseAtEnd),
    .budgetAtEnd(budgetAtEnd),
    .rdData     (rdData)
  );

endmodule

// File: tb/test_nor_erase_engine.sv
`timescale 1ns/1ps
module test_nor_erase_engine;

  localparam int BLK_W = 3;
  localparam int WIN   = 48;
  localparam int BLKC  = 20;
  localparam int MAXC  = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic        forceFail = 1'b0;
  logic [7:0]  rdData;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  nor_erase_engine #(.BLK_W(BLK_W), .WIN_CYC(WIN), .BLK_CYC(BLKC), .MAX_CYC(MAXC))
    i_nor_erase_engine (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
      .busWr(busWr), .busRd(busRd), .forceFail(forceFail), .rdData(rdData));

  // behavioural reference: 0 array, 1..5 sequence steps, 6 window, 7 erase, 8 suspend, 9 fail
  int         mSt = 0;
  logic [7:0] mMap = '0;
  int         mTmo = 0;
  int         mWork = 0;
  int         mElap = 0;
  bit         mTg = 1'b0;
  logic [7:0] mRd = 8'hFF;

  always @(posedge clk) begin
    bit keyA, keyB, setup;
    keyA  = (busAddr[14:0] == 15'h5555) && (busWrData == 8'hAA);
    keyB  = (busAddr[14:0] == 15'h2AAA) && (busWrData == 8'h55);
    setup = (busAddr[14:0] == 15'h5555) && (busWrData == 8'h80);
    if (!rstN) begin
      mSt = 0; mMap = '0; mTg = 1'b0; mRd = 8'hFF;
    end else begin
      if (busRd) begin
        if (mSt == 6 || mSt == 7 || mSt == 9) begin
          mRd = {1'b0, mTg, (mSt == 9), 1'b0, (mSt == 7 || mSt == 9), 3'b000};
          mTg = !mTg;
        end else begin
          mRd = 8'hFF;
        end
      end
      case (mSt)
        0: if (busWr && keyA) mSt = 1;
        1: if (busWr) mSt = keyB ? 2 : 0;
        2: if (busWr) mSt = setup ? 3 : 0;
        3: if (busWr) mSt = keyA ? 4 : 0;
        4: if (busWr) mSt = keyB ? 5 : 0;
        5: if (busWr) begin
             if (busWrData == 8'h30) begin
               mSt = 6; mMap = 8'(1 << busAddr[17:15]); mTmo = 0; mTg = 1'b0;
             end else mSt = 0;
           end
        6: if (busWr) begin
             if (busWrData == 8'h30) begin
               mMap = mMap | 8'(1 << busAddr[17:15]); mTmo = 0;
             end else begin
               mSt = 0; mMap = '0;
             end
           end else if (mTmo == WIN - 1) begin
             mSt = 7; mWork = $countones(mMap) * BLKC; mElap = 0;
           end else mTmo++;
        7: if (busWr && busWrData == 8'hF0) mSt = 0;
           else if (busWr && busWrData == 8'hB0) mSt = 8;
           else begin
             if (!forceFail) mWork--;
             mElap++;
             if (mWork == 0) mSt = 0;
             else if (mElap == MAXC) mSt = 9;
           end
        8: if (busWr && busWrData == 8'h30) mSt = 7;
           else if (busWr && busWrData == 8'hF0) mSt = 0;
        9: if (busWr && busWrData == 8'hF0) mSt = 0;
        default: mSt = 0;
      endcase
    end
  end

  // clock-by-clock comparison with the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (rdData !== mRd) begin
        errors++;
        $display("FAIL %s model compare: actual %02h expected %02h at %0t", curReq, rdData, mRd, $time);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] mask, input logic [7:0] exp);
    @(negedge clk);
    busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    checks++;
    if ((rdData & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s read: actual %02h expected %02h (mask %02h)", req, rdData, exp, mask);
    end
  endtask

  task automatic eraseCmd(input logic [2:0] blk);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    wr({blk, 15'h0123}, 8'h30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    checks++;
    if (rdData !== 8'hFF) begin
      errors++;
      $display("FAIL R1 reset rdData: actual %02h expected ff", rdData);
    end
    rdChk("R1", 8'hFF, 8'hFF);

    // single block: window, erase, completion
    curReq = "R2";
    eraseCmd(3'd2);
    rdChk("R2", 8'hFF, 8'h00);
    rdChk("R7", 8'hFF, 8'h40);
    curReq = "R6";
    idle(50);
    rdChk("R6", 8'h08, 8'h08);
    curReq = "R8";
    idle(40);
    rdChk("R8", 8'hFF, 8'hFF);
    rdChk("R7", 8'hFF, 8'hFF);

    // broken sequences
    curReq = "R3";
    wr(18'h05555, 8'hAA);
    wr(18'h01234, 8'h55);
    wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    wr(18'h10000, 8'h30);
    rdChk("R3", 8'hFF, 8'hFF);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h54);
    wr(18'h10000, 8'h30);
    rdChk("R3", 8'hFF, 8'hFF);

    // multiple blocks, restarted window, duplicate block
    curReq = "R4";
    eraseCmd(3'd1);
    idle(20);
    wr({3'd5, 15'h0}, 8'h30);
    idle(20);
    wr({3'd5, 15'h7FFF}, 8'h30);
    idle(40);
    rdChk("R4", 8'h08, 8'h00);
    idle(30);
    rdChk("R4", 8'h88, 8'h08);
    idle(30);
    rdChk("R4", 8'hFF, 8'hFF);

    // stray value inside the window
    curReq = "R5";
    eraseCmd(3'd3);
    idle(5);
    wr(18'h00000, 8'h80);
    rdChk("R5", 8'hFF, 8'hFF);
    idle(60);
    rdChk("R5", 8'hFF, 8'hFF);

    // ignored writes during erase
    curReq = "R9";
    eraseCmd(3'd0);
    idle(55);
    wr(18'h05555, 8'hAA);
    wr(18'h00000, 8'h80);
    rdChk("R9", 8'h88, 8'h08);
    idle(20);
    rdChk("R9", 8'hFF, 8'hFF);

    // suspend and resume
    curReq = "R10";
    eraseCmd(3'd4);
    idle(52);
    wr(18'h00000, 8'hB0);
    rdChk("R10", 8'hFF, 8'hFF);
    idle(60);
    rdChk("R10", 8'hFF, 8'hFF);
    wr(18'h00000, 8'h30);
    rdChk("R10", 8'h88, 8'h08);
    idle(30);
    rdChk("R10", 8'hFF, 8'hFF);

    // reset write during erase and during suspend
    curReq = "R11";
    eraseCmd(3'd6);
    idle(55);
    wr(18'h00000, 8'hF0);
    rdChk("R11", 8'hFF, 8'hFF);
    idle(40);
    rdChk("R11", 8'hFF, 8'hFF);
    eraseCmd(3'd7);
    idle(52);
    wr(18'h00000, 8'hB0);
    wr(18'h00000, 8'hF0);
    idle(60);
    rdChk("R11", 8'hFF, 8'hFF);

    // forced failure
    curReq = "R12";
    forceFail = 1'b1;
    eraseCmd(3'd7);
    idle(WIN + MAXC + 10);
    rdChk("R12", 8'hBF, 8'h28);
    wr(18'h00000, 8'h30);
    rdChk("R12", 8'hBF, 8'h28);
    wr(18'h00000, 8'hF0);
    rdChk("R12", 8'hFF, 8'hFF);
    forceFail = 1'b0;
    idle(5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule